// File: doc/BRIEF.md
# Parking Gate Hold-Open Timer

This controller raises a parking barrier once an access card has been accepted. It then keeps the barrier up for a fixed hold window, which is ten seconds by default: 500,000,000 cycles of a 50 MHz clock. A lane sensor reports whether a vehicle is standing under the barrier. While the sensor is high, the hold countdown freezes without losing its value. Counting picks up again from the frozen value once the lane is clear.

An arming input lets the surrounding system postpone the countdown. While arming is low and the barrier is up, the count is pinned at zero and the timer flag stays active. A fresh card accepted while the barrier is already up restarts the window. The window length comes from parameters, so a test build can use a window of a few dozen cycles. Motor control, card decoding and sensor filtering belong to neighbouring blocks.

Top module: `gate_hold_timer`

## Requirements
- R1: A card_ok pulse sampled while the barrier is down raises gate_open from the next cycle, whatever the level of arm, and the hold count starts from zero.
- R2: With arm high, lane_busy low and no further card, gate_open stays high for exactly HOLD_CYCLES cycles after the cycle in which the card was sampled, then drops.
- R3: While the barrier is up, arm is high and lane_busy is high, the hold count keeps its value, and timer_run reads low during that cycle.
- R4: When lane_busy returns low, counting resumes from the frozen value, so each frozen cycle lengthens the open time by one cycle.
- R5: While the barrier is up and arm is low, the hold count is held at zero, timer_run reads high and gate_open stays high.
- R6: A card_ok pulse sampled while the barrier is up restarts the hold count from zero.
- R7: While the barrier is down, gate_open and timer_run are both low, and arm and lane_busy have no effect.
- R8: The barrier never drops on an edge at which lane_busy was sampled high, even when the count has reached its final value.
- R9: A low rst_n lowers gate_open at once and clears the count; after rst_n rises, the core leaves reset on the second following rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| card_ok | input | 1 | One-cycle pulse when an access card is accepted |
| arm | input | 1 | Countdown enable; low pins the hold count at zero |
| lane_busy | input | 1 | Vehicle-presence sensor, high while a car is in the lane |
| gate_open | output | 1 | Barrier-up command, high while the barrier must be raised |
| timer_run | output | 1 | High while the barrier is up and the countdown is not frozen by the sensor |

## Verification
A hold count that drifts, or that clears when it should freeze, shows at the ports only as a change in when gate_open falls. That change appears at the end of the window, up to HOLD_CYCLES cycles after the fault, so every scenario is followed through to the falling edge of gate_open and checked in every cycle. A wrong control state shows sooner. A stuck barrier state or a bad freeze decision corrupts gate_open or timer_run in the very cycle it happens, because timer_run is decoded directly from the state and the present sensor and arm levels.

// File: rtl/gate_hold_pkg.sv
package gate_hold_pkg;

  typedef enum logic {
    GH_CLOSED = 1'b0,
    GH_OPEN   = 1'b1
  } gh_state_e;

endpackage

// File: rtl/gate_hold_rst_sync.sv
module gate_hold_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/gate_hold_counter.sv
module gate_hold_counter #(
  parameter int unsigned HOLD_CYCLES = 20,
  parameter int unsigned CNT_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  // clear wins over increment; with neither, the value is frozen
  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt  = cnt_q;
  assign last = (cnt_q == LAST_VAL);

endmodule

// File: rtl/gate_hold_fsm.sv
module gate_hold_fsm
  import gate_hold_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      card_ok,
  input  logic      arm,
  input  logic      lane_busy,
  input  logic      cnt_last,
  output logic      cnt_clr,
  output logic      cnt_en,
  output gh_state_e state,
  output logic      timer_run
);

  gh_state_e state_q;
  gh_state_e state_d;

  // priority while open: new card, then arm low, then sensor freeze, then count
  always_comb begin
    state_d = state_q;
    cnt_clr = 1'b0;
    cnt_en  = 1'b0;
    case (state_q)
      GH_CLOSED: begin
        if (card_ok) begin
          state_d = GH_OPEN;
          cnt_clr = 1'b1;
        end
      end
      GH_OPEN: begin
        if (card_ok) begin
          cnt_clr = 1'b1;
        end else if (!arm) begin
          cnt_clr = 1'b1;
        end else if (!lane_busy) begin
          if (cnt_last) begin
            state_d = GH_CLOSED;
            cnt_clr = 1'b1;
          end else begin
            cnt_en = 1'b1;
          end
        end
      end
      default: begin
        state_d = GH_CLOSED;
        cnt_clr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GH_CLOSED;
    end else begin
      state_q <= state_d;
    end
  end

  assign state     = state_q;
  assign timer_run = (state_q == GH_OPEN) && !(arm && lane_busy);

endmodule

// File: rtl/gate_hold_timer.sv
module gate_hold_timer
  import gate_hold_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned HOLD_SEC    = 10,
  parameter int unsigned HOLD_CYCLES = CLK_HZ * HOLD_SEC,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic card_ok,
  input  logic arm,
  input  logic lane_busy,
  output logic gate_open,
  output logic timer_run
);

  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES);

  logic             rst_core_n;
  logic             cnt_clr;
  logic             cnt_en;
  logic             cnt_last;
  logic [CNT_W-1:0] hold_cnt;
  gh_state_e        state;

  gate_hold_rst_sync #(
    .STAGES(RST_STAGES)
  ) rst_sync_i (
    .clk        (clk),
    .rst_n_async(rst_n),
    .rst_n_sync (rst_core_n)
  );

  gate_hold_fsm fsm_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .card_ok  (card_ok),
    .arm      (arm),
    .lane_busy(lane_busy),
    .cnt_last (cnt_last),
    .cnt_clr  (cnt_clr),
    .cnt_en   (cnt_en),
    .state    (state),
    .timer_run(timer_run)
  );

  gate_hold_counter #(
    .HOLD_CYCLES(HOLD_CYCLES),
    .CNT_W      (CNT_W)
  ) cnt_i (
    .clk  (clk),
    .rst_n(rst_core_n),
    .clr  (cnt_clr),
    .en   (cnt_en),
    .cnt  (hold_cnt),
    .last (cnt_last)
  );

  assign gate_open = (state == GH_OPEN);

endmodule

// File: rtl/gate_hold_checker.sv
module gate_hold_checker #(
  parameter int unsigned HOLD_CYCLES = 20,
  parameter int unsigned CNT_W       = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             card_ok,
  input logic             arm,
  input logic             lane_busy,
  input logic             gate_open,
  input logic             timer_run,
  input logic [CNT_W-1:0] cnt
);

  assert_card_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
    card_ok |=> (gate_open && cnt == '0));

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(HOLD_CYCLES));

  assert_close_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_open) |-> ($past(cnt) == CNT_W'(HOLD_CYCLES - 1)));

  assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_open && arm && lane_busy && !card_ok) |=> ($stable(cnt) && gate_open));

  assert_arm_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_open && !arm && !card_ok) |=> (gate_open && cnt == '0));

  assert_closed_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_open |-> !timer_run);

  assert_no_close_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_open) |-> !$past(lane_busy));

endmodule

bind gate_hold_timer gate_hold_checker #(
  .HOLD_CYCLES(HOLD_CYCLES),
  .CNT_W      (CNT_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .card_ok  (card_ok),
  .arm      (arm),
  .lane_busy(lane_busy),
  .gate_open(gate_open),
  .timer_run(timer_run),
  .cnt      (hold_cnt)
);

// File: tb/gate_hold_timer_tb_top.sv
`timescale 1ns/1ps
module gate_hold_timer_tb_top;

  localparam int HOLD = 20;

  typedef struct {
    logic  g;
    logic  r;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic card_ok;
  logic arm;
  logic lane_busy;
  logic gate_open;
  logic timer_run;

  exp_t sb_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // reference model state
  bit m_open = 1'b0;
  int m_cnt  = 0;

  always #4 clk = ~clk;

  gate_hold_timer #(
    .HOLD_CYCLES(HOLD)
  ) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .card_ok  (card_ok),
    .arm      (arm),
    .lane_busy(lane_busy),
    .gate_open(gate_open),
    .timer_run(timer_run)
  );

  // driver: one cycle of stimulus, expected outputs pushed, model advanced
  task automatic step(input logic rn, input logic c, input logic a,
                      input logic b, input string tag);
    exp_t e;
    @(negedge clk);
    rst_n     = rn;
    card_ok   = c;
    arm       = a;
    lane_busy = b;
    if (!rn) begin
      m_open = 1'b0;
      m_cnt  = 0;
    end
    e.g   = m_open;
    e.r   = m_open && !(a && b);
    e.tag = tag;
    sb_q.push_back(e);
    if (rn) begin
      if (!m_open) begin
        if (c) begin
          m_open = 1'b1;
          m_cnt  = 0;
        end
      end else if (c) begin
        m_cnt = 0;
      end else if (!a) begin
        m_cnt = 0;
      end else if (!b) begin
        if (m_cnt == HOLD - 1) begin
          m_open = 1'b0;
          m_cnt  = 0;
        end else begin
          m_cnt++;
        end
      end
    end
  endtask

  task automatic run(input int n, input logic a, input logic b, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, a, b, tag);
  endtask

  // monitor: compare outputs well after the inputs settle, before the next edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_cmp++;
        if (gate_open !== e.g || timer_run !== e.r) begin
          n_bad++;
          $display("FAIL %s: gate_open=%b timer_run=%b expected gate_open=%b timer_run=%b",
                   e.tag, gate_open, timer_run, e.g, e.r);
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0; card_ok = 1'b0; arm = 1'b0; lane_busy = 1'b0;
    // R9: reset state, then synchronous release
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b0, "R9");
    run(3, 1'b1, 1'b0, "R9");
    // R7: arm and sensor ignored while closed
    run(2, 1'b1, 1'b1, "R7");
    run(2, 1'b0, 1'b1, "R7");
    // R1 + R2: plain window
    step(1'b1, 1'b1, 1'b1, 1'b0, "R1");
    run(24, 1'b1, 1'b0, "R2");
    // R3 + R4: freeze mid-window, then resume
    step(1'b1, 1'b1, 1'b1, 1'b0, "R1");
    run(5, 1'b1, 1'b0, "R4");
    run(6, 1'b1, 1'b1, "R3");
    run(18, 1'b1, 1'b0, "R4");
    // R5: arm low pins count at zero
    step(1'b1, 1'b1, 1'b1, 1'b0, "R1");
    run(4, 1'b1, 1'b0, "R5");
    run(3, 1'b0, 1'b0, "R5");
    run(2, 1'b0, 1'b1, "R5");
    run(22, 1'b1, 1'b0, "R5");
    // R6: new card restarts the window
    step(1'b1, 1'b1, 1'b1, 1'b0, "R1");
    run(10, 1'b1, 1'b0, "R6");
    step(1'b1, 1'b1, 1'b1, 1'b0, "R6");
    run(22, 1'b1, 1'b0, "R6");
    // R8: sensor high at the final count holds the barrier
    step(1'b1, 1'b1, 1'b1, 1'b0, "R1");
    run(19, 1'b1, 1'b0, "R8");
    run(4, 1'b1, 1'b1, "R8");
    run(3, 1'b1, 1'b0, "R8");
    // R1: card accepted while arm is low
    step(1'b1, 1'b1, 1'b0, 1'b0, "R1");
    run(3, 1'b0, 1'b0, "R5");
    run(22, 1'b1, 1'b0, "R2");
    // R9: reset in the middle of a window
    step(1'b1, 1'b1, 1'b1, 1'b0, "R1");
    run(5, 1'b1, 1'b0, "R9");
    for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 1'b1, 1'b0, "R9");
    run(3, 1'b1, 1'b0, "R9");
    run(2, 1'b1, 1'b0, "R7");
    // drain
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run still active=1 expected finished=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule